// File: doc/BRIEF.md
# Extended Effective Address Generator

This block forms the effective address for indexed addressing modes. It adds an address-register base, an index operand that is scaled by a power of two, and a sign-extended displacement. The index comes from either a data register value or an address register value. The scale range runs from x1 up to x16. An optional negate turns the index addition into a subtraction. Negation costs only an inversion of the scaled index and a carry into the adder, so the adder's critical path stays the same.

The result is registered. One cycle after an accepted request, the block presents the address together with a routing flag and an optional writeback. The routing flag says whether the address goes to a memory fetch or straight to the ALU as an operand value (direct mode). The writeback returns the computed address to the base address register. Writeback is refused whenever the base term is suppressed. The writeback target is always an address register number and never a data register.

Top module: `eff_addr_gen`

## Requirements
- R1: When `in_valid` is high on a clock edge, the output stage captures the result and shows it after that edge. `ea_out` then equals base + scaled index + `disp`, modulo 2^32, and `out_valid` is high.
- R2: `idx_is_addr` = 1 selects `addr_idx` as the index operand, and 0 selects `data_idx`.
- R3: `scale_code` values 0, 1, 2, 3 and 4 scale the index by 1, 2, 4, 8 and 16, which is a left shift by the code. The reserved codes 5, 6 and 7 scale by 1.
- R4: With `negate` = 1, the result is base − (index × scale) + `disp`, modulo 2^32.
- R5: With `idx_suppress` = 1, the index term is zero and `negate` has no effect on `ea_out`.
- R6: With `base_suppress` = 1, the base term is zero.
- R7: With `direct` = 1, an accepted request gives `to_alu` = 1 and `mem_req` = 0. With `direct` = 0, it gives `mem_req` = 1 and `to_alu` = 0.
- R8: `wb_en` goes high after an accepted request only when `base_update` = 1 and `base_suppress` = 0. When it does, `wb_value` equals the computed address and `wb_reg` equals `base_reg`.
- R9: While reset is asserted, and until the first accepted request, `out_valid`, `mem_req`, `to_alu` and `wb_en` are 0.
- R10: After an edge with `in_valid` = 0, all four strobes are 0, and `ea_out`, `wb_value` and `wb_reg` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request accepted on this edge |
| base_val | input | 32 | Base address register value |
| base_reg | input | 3 | Number of the base address register |
| base_suppress | input | 1 | Force the base term to zero |
| base_update | input | 1 | Request writeback of the result to the base register |
| data_idx | input | 32 | Index candidate from a data register |
| addr_idx | input | 32 | Index candidate from an address register |
| idx_is_addr | input | 1 | 1 = use addr_idx, 0 = use data_idx |
| idx_suppress | input | 1 | Force the index term to zero |
| scale_code | input | 3 | Index scale: 0..4 give x1..x16, 5..7 give x1 |
| negate | input | 1 | Subtract the scaled index instead of adding it |
| disp | input | 32 | Sign-extended displacement |
| direct | input | 1 | Route the result to the ALU instead of memory |
| out_valid | output | 1 | Result registers hold a fresh result |
| ea_out | output | 32 | Computed effective address |
| mem_req | output | 1 | Memory fetch requested at ea_out |
| to_alu | output | 1 | ea_out is an ALU operand |
| wb_en | output | 1 | Write wb_value to address register wb_reg |
| wb_reg | output | 3 | Writeback address register number |
| wb_value | output | 32 | Writeback value |

## Verification
Every path from an input to the output stage passes through exactly one register. So a wrong scale selection, a wrong operand choice or a wrong negate carry shows up as a wrong `ea_out` on the first edge after the request, and that cycle exposes it at once. Faults in the strobes show up in the same way. A writeback that escapes through a suppressed base, or a wrong routing flag, appears at `wb_en`, `mem_req` or `to_alu` one cycle after the request. Stale or corrupted held values surface on the idle cycles that follow an accepted request, because the bench compares every output on every cycle against an arithmetic model that uses multiplication and true subtraction.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W    = 32;
  localparam int SCALE_W   = 3;
  localparam int MAX_SHIFT = 4;
  localparam int REG_W     = 3;

  // Shift amount for a scale code; reserved codes fall back to x1.
  function automatic int unsigned shift_of(input logic [SCALE_W-1:0] code);
    if (int'(code) <= MAX_SHIFT) return int'(code);
    return 0;
  endfunction

  // Conditional one's complement; the +1 half of negation enters as carry.
  function automatic logic [ADDR_W-1:0] cond_invert(input logic [ADDR_W-1:0] v,
                                                    input logic inv);
    return v ^ {ADDR_W{inv}};
  endfunction
endpackage

// File: rtl/ea_index_scaler.sv
module ea_index_scaler
  import ea_pkg::*;
#(
  parameter int W    = ADDR_W,
  parameter int SCW  = SCALE_W,
  parameter int MAXS = MAX_SHIFT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   data_idx,
  input  logic [W-1:0]   addr_idx,
  input  logic           idx_is_addr,
  input  logic           idx_suppress,
  input  logic [SCW-1:0] scale_code,
  input  logic           negate,
  output logic [W-1:0]   term,
  output logic           carry_in
);
  localparam int NOPT = MAXS + 1;

  logic [W-1:0] raw_idx;
  logic [W-1:0] gated_idx;
  logic [W-1:0] shifted;
  logic [W-1:0] cand [NOPT];

  assign raw_idx   = idx_is_addr ? addr_idx : data_idx;
  assign gated_idx = idx_suppress ? '0 : raw_idx;

  // One mux leg per legal shift amount.
  for (genvar s = 0; s < NOPT; s++) begin : g_leg
    assign cand[s] = gated_idx << s;
  end

  always_comb begin
    shifted = cand[0];
    for (int s = 0; s < NOPT; s++)
      if (shift_of(scale_code) == s) shifted = cand[s];
  end

  assign term     = cond_invert(shifted, negate);
  assign carry_in = negate;

  // R4
  negate_twos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    negate |-> (term + {{(W-1){1'b0}}, carry_in}) == (~shifted + 1'b1));
  // R5
  suppress_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_suppress |-> (term + {{(W-1){1'b0}}, carry_in}) == '0);
endmodule

// File: rtl/ea_adder3.sv
module ea_adder3 #(
  parameter int W = 32
) (
  input  logic [W-1:0] base_term,
  input  logic [W-1:0] idx_term,
  input  logic [W-1:0] disp_term,
  input  logic         cin,
  output logic [W-1:0] sum
);
  assign sum = base_term + idx_term + disp_term + {{(W-1){1'b0}}, cin};
endmodule

// File: rtl/ea_out_stage.sv
module ea_out_stage #(
  parameter int W  = 32,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  sum,
  input  logic          direct,
  input  logic          wb_allowed,
  input  logic [RW-1:0] base_reg,
  output logic          out_valid,
  output logic [W-1:0]  ea_out,
  output logic          mem_req,
  output logic          to_alu,
  output logic          wb_en,
  output logic [RW-1:0] wb_reg,
  output logic [W-1:0]  wb_value
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mem_req   <= 1'b0;
      to_alu    <= 1'b0;
      wb_en     <= 1'b0;
      ea_out    <= '0;
      wb_value  <= '0;
      wb_reg    <= '0;
    end else begin
      out_valid <= in_valid;
      mem_req   <= in_valid & ~direct;
      to_alu    <= in_valid & direct;
      wb_en     <= in_valid & wb_allowed;
      if (in_valid) begin
        ea_out   <= sum;
        wb_value <= sum;
        wb_reg   <= base_reg;
      end
    end
  end

  // R7
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (mem_req | to_alu));
  // R8
  wb_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> out_valid && wb_value == ea_out);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(ea_out) && $stable(wb_reg));
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [REG_W-1:0]  base_reg,
  input  logic              base_suppress,
  input  logic              base_update,
  input  logic [ADDR_W-1:0] data_idx,
  input  logic [ADDR_W-1:0] addr_idx,
  input  logic              idx_is_addr,
  input  logic              idx_suppress,
  input  logic [SCALE_W-1:0] scale_code,
  input  logic              negate,
  input  logic [ADDR_W-1:0] disp,
  input  logic              direct,
  output logic              out_valid,
  output logic [ADDR_W-1:0] ea_out,
  output logic              mem_req,
  output logic              to_alu,
  output logic              wb_en,
  output logic [REG_W-1:0]  wb_reg,
  output logic [ADDR_W-1:0] wb_value
);
  logic [ADDR_W-1:0] idx_term;
  logic              idx_cin;
  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] ea_sum;
  logic              wb_allowed;

  assign base_term  = base_suppress ? '0 : base_val;
  assign wb_allowed = base_update & ~base_suppress;

  ea_index_scaler #(.W(ADDR_W), .SCW(SCALE_W), .MAXS(MAX_SHIFT)) u_scaler (
    .clk(clk), .rst_n(rst_n),
    .data_idx(data_idx), .addr_idx(addr_idx), .idx_is_addr(idx_is_addr),
    .idx_suppress(idx_suppress), .scale_code(scale_code), .negate(negate),
    .term(idx_term), .carry_in(idx_cin)
  );

  ea_adder3 #(.W(ADDR_W)) u_adder (
    .base_term(base_term), .idx_term(idx_term), .disp_term(disp),
    .cin(idx_cin), .sum(ea_sum)
  );

  ea_out_stage #(.W(ADDR_W), .RW(REG_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sum(ea_sum),
    .direct(direct), .wb_allowed(wb_allowed), .base_reg(base_reg),
    .out_valid(out_valid), .ea_out(ea_out), .mem_req(mem_req),
    .to_alu(to_alu), .wb_en(wb_en), .wb_reg(wb_reg), .wb_value(wb_value)
  );

  // R1
  ea_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && ea_out == $past(ea_sum));
  // R8
  no_wb_suppressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && base_suppress) |=> !wb_en);
  // R6
  base_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && base_suppress && idx_suppress) |=> ea_out == $past(disp));
endmodule

// File: tb/eff_addr_gen_tb.sv
module eff_addr_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] base_val = '0, data_idx = '0, addr_idx = '0, disp = '0;
  logic [2:0]  base_reg = '0, scale_code = '0;
  logic base_suppress = 1'b0, base_update = 1'b0, idx_is_addr = 1'b0;
  logic idx_suppress = 1'b0, negate = 1'b0, direct = 1'b0;
  logic out_valid, mem_req, to_alu, wb_en;
  logic [31:0] ea_out, wb_value;
  logic [2:0]  wb_reg;

  int tests = 0, fails = 0;
  logic [31:0] x_ea = '0, x_wbv = '0;
  logic [2:0]  x_wbr = '0;
  logic x_ov = 0, x_mr = 0, x_alu = 0, x_wb = 0;

  always #10 clk = ~clk;

  eff_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
    .base_reg(base_reg), .base_suppress(base_suppress), .base_update(base_update),
    .data_idx(data_idx), .addr_idx(addr_idx), .idx_is_addr(idx_is_addr),
    .idx_suppress(idx_suppress), .scale_code(scale_code), .negate(negate),
    .disp(disp), .direct(direct), .out_valid(out_valid), .ea_out(ea_out),
    .mem_req(mem_req), .to_alu(to_alu), .wb_en(wb_en), .wb_reg(wb_reg),
    .wb_value(wb_value)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural model: multiply for scale, true subtraction for negate.
  function automatic logic [31:0] model_ea();
    logic [31:0] idx, mult, t, b;
    idx  = idx_suppress ? 32'd0 : (idx_is_addr ? addr_idx : data_idx);
    mult = (scale_code < 3'd5) ? (32'd1 << scale_code) : 32'd1;
    t    = idx * mult;
    b    = base_suppress ? 32'd0 : base_val;
    return negate ? (b - t + disp) : (b + t + disp);
  endfunction

  // Called at a negedge: expected results for the inputs now applied.
  task automatic step(input string tag);
    x_ov  = in_valid;
    x_mr  = in_valid & ~direct;
    x_alu = in_valid & direct;
    x_wb  = in_valid & base_update & ~base_suppress;
    if (in_valid) begin
      x_ea  = model_ea();
      x_wbv = x_ea;
      x_wbr = base_reg;
    end
    @(negedge clk);
    chk(tag, "out_valid", {31'd0, out_valid}, {31'd0, x_ov});
    chk(tag, "ea_out", ea_out, x_ea);
    chk(tag, "mem_req", {31'd0, mem_req}, {31'd0, x_mr});
    chk(tag, "to_alu", {31'd0, to_alu}, {31'd0, x_alu});
    chk(tag, "wb_en", {31'd0, wb_en}, {31'd0, x_wb});
    chk(tag, "wb_value", wb_value, x_wbv);
    chk(tag, "wb_reg", {29'd0, wb_reg}, {29'd0, x_wbr});
  endtask

  task automatic clear_ctl();
    in_valid = 1; base_suppress = 0; base_update = 0; idx_is_addr = 0;
    idx_suppress = 0; negate = 0; direct = 0; scale_code = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        step("R9 reset");
        rst_n = 1'b1;
        step("R9 idle after reset");
        // R1 basic sum
        clear_ctl(); base_val = 32'h1000_0000; data_idx = 32'h10; disp = 32'h4;
        step("R1 base+idx+disp");
        disp = 32'hFFFF_FFF0; base_val = 32'hFFFF_FFF8; data_idx = 32'h20;
        step("R1 wraparound");
        // R2 operand select
        data_idx = 32'h11; addr_idx = 32'h2200; base_val = 32'h100; disp = 0;
        idx_is_addr = 1; step("R2 addr index");
        idx_is_addr = 0; step("R2 data index");
        // R3 every scale code
        for (int c = 0; c < 8; c++) begin
          scale_code = 3'(c); data_idx = 32'h0F00_0003;
          step($sformatf("R3 scale code %0d", c));
        end
        // R4 negate
        scale_code = 3; negate = 1; base_val = 32'h8000; data_idx = 32'h10;
        disp = 32'h2; step("R4 negate");
        data_idx = 0; step("R4 negate zero index");
        scale_code = 4; data_idx = 32'h1000_0000; step("R4 negate x16");
        // R5 suppressed index ignores negate
        idx_suppress = 1; data_idx = 32'h1234; step("R5 suppressed idx negate");
        negate = 0; step("R5 suppressed idx");
        // R6 / R8 suppressed base blocks writeback
        idx_suppress = 0; negate = 0; base_suppress = 1; base_update = 1;
        base_reg = 3'd5; step("R6 R8 base suppressed");
        // R8 writeback
        base_suppress = 0; base_reg = 3'd6; step("R8 writeback");
        // R7 direct routing
        direct = 1; step("R7 direct");
        direct = 0; base_update = 0; step("R7 memory");
        // R10 idle holds
        in_valid = 0; base_val = 32'hDEAD_BEEF; base_reg = 3'd1;
        step("R10 idle hold");
        step("R10 idle hold 2");
        // Mixed random traffic
        for (int i = 0; i < 400; i++) begin
          in_valid = ($urandom_range(0, 3) != 0);
          base_val = $urandom; data_idx = $urandom; addr_idx = $urandom;
          disp = $urandom; base_reg = 3'($urandom);
          scale_code = 3'($urandom); idx_is_addr = 1'($urandom);
          idx_suppress = ($urandom_range(0, 7) == 0);
          base_suppress = ($urandom_range(0, 7) == 0);
          base_update = 1'($urandom); negate = 1'($urandom);
          direct = 1'($urandom);
          step("R1 R7 R8 R10 random");
        end
      end
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule